// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Unit with Excess Output

This unit takes a 5-bit operation code and two 16-bit operands, named `b` (the destination-side operand) and `a` (the source-side operand). It returns a 16-bit result and a 16-bit excess word. The excess word carries the side value of the operation: the carry or borrow, the upper half of a product, the fractional part of a quotient, or the bits shifted out. A separate flag tells the surrounding pipeline whether its excess register must be overwritten. When the flag is low, the excess register keeps its old value.

Operations enter on a valid/ready stream. An operation is accepted on a rising edge when `in_valid` and `in_ready` are both high. The unit holds one operation at a time, so `in_ready` stays low from acceptance until the result has been taken. The result leaves on a second valid/ready stream. While `out_ready` is low, the result stays on the port unchanged and no new operation is accepted, so back-pressure on the output stalls the input. The number of cycles depends on the operation code, so the caller can use simple operations faster than divides.

Top module: `xs_alu`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only while no operation is in progress and no result is waiting. It is never 1 while `out_valid` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_res`, `out_ex` and `out_ex_we` hold their values on the next cycle. A result is consumed on an edge where `out_valid` and `out_ready` are both 1.
- R3: Count the accepting edge as edge 1. `out_valid` first rises on edge N, where N is:
  - 1 for codes 0x01, 0x09, 0x0a and 0x0b, and for all unlisted codes;
  - 2 for codes 0x02, 0x03, 0x04, 0x05, 0x0c, 0x0d and 0x0e;
  - 3 for codes 0x06, 0x07 and 0x08.
- R4: Add (0x02) gives (b+a) mod 2^16. Excess is 0x0001 if the true sum exceeds 0xffff and 0x0000 otherwise. `out_ex_we` is 1.
- R5: Subtract (0x03) gives (b−a) mod 2^16. Excess is 0xffff if b<a as unsigned numbers and 0x0000 otherwise. `out_ex_we` is 1.
- R6: Multiply returns the low 16 bits of the product as the result and bits 31..16 as excess, with `out_ex_we` 1. Code 0x04 treats both operands as unsigned and code 0x05 as two's complement.
- R7: Divide with a≠0 sets `out_ex_we` to 1. Code 0x06 is unsigned: the result is b/a and the excess is the low 16 bits of (b·2^16)/a. Code 0x07 is the two's-complement form of the same, and its quotients truncate toward zero.
- R8: With a=0, codes 0x06 and 0x07 give result 0 and excess 0 with `out_ex_we` 1. Remainder (0x08) gives result 0.
- R9: Shift count is the whole 16-bit `a`. Logical right shift (0x0c) gives b>>a, with excess equal to the low 16 bits of (b·2^16)>>a. Arithmetic right shift (0x0d) does the same with `b` sign-extended. Both set `out_ex_we` to 1.
- R10: Left shift (0x0e) gives the low 16 bits of b<<a. Excess is bits 31..16 of b<<a, that is the bits pushed out above bit 15. `out_ex_we` is 1.
- R11: The following codes give `out_ex_we` 0 and `out_ex` 0x0000:
  - Copy (0x01), whose result is `a`;
  - AND (0x09), OR (0x0a) and XOR (0x0b), each on b and a;
  - Remainder (0x08), whose result is b mod a when a≠0.
- R12: Any code not listed above returns `b` unchanged, with `out_ex_we` 0 and `out_ex` 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 5 | Operation code |
| in_b | input | 16 | Destination-side operand b |
| in_a | input | 16 | Source-side operand a |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Result word |
| out_ex | output | 16 | Excess word |
| out_ex_we | output | 1 | Excess register must be written |

## Verification
A wrong latency count shows as `out_valid` rising one or more edges early or late after acceptance. The bench measures this on every operation. A corrupted state machine shows as `in_ready` and `out_valid` being high together, or as a result that changes while stalled; both are visible within one cycle. Wrong arithmetic in the side value shows only on `out_ex` and `out_ex_we`. The carry, borrow, divide-by-zero, sign and large-shift cases are therefore each driven on purpose, and every result is compared with an independent model at the moment it is consumed.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int OPC_W = 5;
  localparam int LAT_W = 2;

  localparam logic [OPC_W-1:0] OP_COPY = 5'h01;
  localparam logic [OPC_W-1:0] OP_ADD  = 5'h02;
  localparam logic [OPC_W-1:0] OP_SUB  = 5'h03;
  localparam logic [OPC_W-1:0] OP_MULU = 5'h04;
  localparam logic [OPC_W-1:0] OP_MULS = 5'h05;
  localparam logic [OPC_W-1:0] OP_DIVU = 5'h06;
  localparam logic [OPC_W-1:0] OP_DIVS = 5'h07;
  localparam logic [OPC_W-1:0] OP_REM  = 5'h08;
  localparam logic [OPC_W-1:0] OP_AND  = 5'h09;
  localparam logic [OPC_W-1:0] OP_OR   = 5'h0a;
  localparam logic [OPC_W-1:0] OP_XOR  = 5'h0b;
  localparam logic [OPC_W-1:0] OP_SRL  = 5'h0c;
  localparam logic [OPC_W-1:0] OP_SRA  = 5'h0d;
  localparam logic [OPC_W-1:0] OP_SLL  = 5'h0e;

  // Cycle class of each operation code
  function automatic logic [LAT_W-1:0] op_latency(logic [OPC_W-1:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MULU, OP_MULS,
      OP_SRL, OP_SRA, OP_SLL:            return LAT_W'(2);
      OP_DIVU, OP_DIVS, OP_REM:          return LAT_W'(3);
      default:                           return LAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/xs_compute.sv
module xs_compute
  import xs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     a,
  output logic [W-1:0]     res,
  output logic [W-1:0]     ex,
  output logic             ex_we
);
  localparam int W2 = 2 * W;
  localparam int W3 = 3 * W;

  logic              a_zero;
  logic [W-1:0]      a_safe;
  logic [W:0]        sum;
  logic [W2-1:0]     prod_u;
  logic signed [W2-1:0] prod_s;
  logic [W2-1:0]     q_hi_u;
  logic signed [W3-1:0] sb_ext, sb_hi, sa_ext, q_s, q_hi_s;
  logic [W2-1:0]     b_up, srl_v, sll_v;
  logic signed [W2-1:0] sra_v;

  always_comb begin
    a_zero = (a == '0);
    a_safe = a_zero ? W'(1) : a;
    sum    = {1'b0, b} + {1'b0, a};
    prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
    prod_s = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});
    b_up   = {b, {W{1'b0}}};
    q_hi_u = b_up / {{W{1'b0}}, a_safe};
    sb_ext = $signed({{W2{b[W-1]}}, b});
    sb_hi  = $signed({{W{b[W-1]}}, b, {W{1'b0}}});
    sa_ext = $signed({{W2{a_safe[W-1]}}, a_safe});
    q_s    = sb_ext / sa_ext;
    q_hi_s = sb_hi / sa_ext;
    srl_v  = b_up >> a;
    sra_v  = $signed(b_up) >>> a;
    sll_v  = {{W{1'b0}}, b} << a;
  end

  always_comb begin
    res   = b;
    ex    = '0;
    ex_we = 1'b0;
    case (op)
      OP_COPY: res = a;
      OP_AND:  res = b & a;
      OP_OR:   res = b | a;
      OP_XOR:  res = b ^ a;
      OP_ADD: begin
        res = sum[W-1:0]; ex = W'(sum[W]); ex_we = 1'b1;
      end
      OP_SUB: begin
        res = b - a; ex = (b < a) ? '1 : '0; ex_we = 1'b1;
      end
      OP_MULU: begin
        res = prod_u[W-1:0]; ex = prod_u[W2-1:W]; ex_we = 1'b1;
      end
      OP_MULS: begin
        res = prod_s[W-1:0]; ex = prod_s[W2-1:W]; ex_we = 1'b1;
      end
      OP_DIVU: begin
        res   = a_zero ? '0 : b / a_safe;
        ex    = a_zero ? '0 : q_hi_u[W-1:0];
        ex_we = 1'b1;
      end
      OP_DIVS: begin
        res   = a_zero ? '0 : q_s[W-1:0];
        ex    = a_zero ? '0 : q_hi_s[W-1:0];
        ex_we = 1'b1;
      end
      OP_REM:  res = a_zero ? '0 : b % a_safe;
      OP_SRL: begin
        res = srl_v[W2-1:W]; ex = srl_v[W-1:0]; ex_we = 1'b1;
      end
      OP_SRA: begin
        res = sra_v[W2-1:W]; ex = sra_v[W-1:0]; ex_we = 1'b1;
      end
      OP_SLL: begin
        res = sll_v[W-1:0]; ex = sll_v[W2-1:W]; ex_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xs_seq.sv
module xs_seq
  import xs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [LAT_W-1:0] lat,
  output logic             in_ready,
  output logic             out_valid,
  output logic             accept
);
  typedef enum logic [1:0] {S_IDLE, S_WORK, S_DONE} seq_state_e;

  seq_state_e       state;
  logic [LAT_W-1:0] remain;

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_DONE);
  assign accept    = in_ready && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      remain <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (lat <= LAT_W'(1)) state <= S_DONE;
          else begin
            state  <= S_WORK;
            remain <= lat - LAT_W'(2);
          end
        end
        S_WORK: begin
          if (remain == '0) state <= S_DONE;
          else remain <= remain - LAT_W'(1);
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xs_alu.sv
module xs_alu
  import xs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_op,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     in_a,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_res,
  output logic [W-1:0]     out_ex,
  output logic             out_ex_we
);
  logic [LAT_W-1:0] lat;
  logic [W-1:0]     c_res, c_ex;
  logic             c_we, accept;

  assign lat = op_latency(in_op);

  xs_compute #(.W(W)) u_cmp (
    .op(in_op), .b(in_b), .a(in_a),
    .res(c_res), .ex(c_ex), .ex_we(c_we)
  );

  xs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .lat(lat), .in_ready(in_ready), .out_valid(out_valid), .accept(accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_res   <= '0;
      out_ex    <= '0;
      out_ex_we <= 1'b0;
    end else if (accept) begin
      out_res   <= c_res;
      out_ex    <= c_ex;
      out_ex_we <= c_we;
    end
  end
endmodule

// File: rtl/xs_alu_chk.sv
module xs_alu_chk
  import xs_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OPC_W-1:0] in_op,
  input logic [W-1:0]     in_a,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_res,
  input logic [W-1:0]     out_ex,
  input logic             out_ex_we
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)
                                   && $stable(out_ex) && $stable(out_ex_we)));

  a_r3_lat1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_latency(in_op) == 2'd1) |=> out_valid);

  a_r3_lat2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_latency(in_op) == 2'd2) |=> !out_valid ##1 out_valid);

  a_r3_lat3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_latency(in_op) == 2'd3) |=> !out_valid ##1 !out_valid ##1 out_valid);

  a_r4_add_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADD) |-> ##2 (out_ex_we && out_ex[W-1:1] == '0));

  a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_DIVU || in_op == OP_DIVS) && in_a == '0)
      |-> ##3 (out_res == '0 && out_ex == '0 && out_ex_we));

  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_COPY || in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR))
      |=> (!out_ex_we && out_ex == '0));
endmodule

bind xs_alu xs_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_xs_alu.sv
module tb_xs_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [15:0] in_b = '0, in_a = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_res, out_ex;
  logic        out_ex_we;

  xs_alu dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [15:0] res;
    logic [15:0] ex;
    logic        we;
    int          lat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0, cyc = 0, acc_cyc = 0;
  bit   stall_mode = 0, seen = 0, prev_stall = 0, finished = 0;
  logic [15:0] prev_res, prev_ex;
  logic        prev_we;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    out_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [32:0] model(logic [4:0] op, logic [15:0] b, logic [15:0] a);
    longint ub, ua, sb, sa, x;
    logic [15:0] r, e;
    logic w;
    ub = longint'(b); ua = longint'(a);
    sb = longint'($signed(b)); sa = longint'($signed(a));
    r = b; e = 16'h0; w = 1'b0; x = 0;
    case (op)
      5'h01: r = a;
      5'h02: begin x = ub + ua; r = x[15:0]; e = (x > 65535) ? 16'h1 : 16'h0; w = 1; end
      5'h03: begin r = b - a; e = (b < a) ? 16'hffff : 16'h0; w = 1; end
      5'h04: begin x = ub * ua; r = x[15:0]; e = x[31:16]; w = 1; end
      5'h05: begin x = sb * sa; r = x[15:0]; e = x[31:16]; w = 1; end
      5'h06: begin
        w = 1;
        if (a == 0) begin r = 0; e = 0; end
        else begin x = ub / ua; r = x[15:0]; x = (ub * 65536) / ua; e = x[15:0]; end
      end
      5'h07: begin
        w = 1;
        if (a == 0) begin r = 0; e = 0; end
        else begin x = sb / sa; r = x[15:0]; x = (sb * 65536) / sa; e = x[15:0]; end
      end
      5'h08: r = (a == 0) ? 16'h0 : 16'(ub % ua);
      5'h09: r = b & a;
      5'h0a: r = b | a;
      5'h0b: r = b ^ a;
      5'h0c: begin x = (ub * 65536) >> ua; r = x[31:16]; e = x[15:0]; w = 1; end
      5'h0d: begin x = (sb * 65536) >>> ua; r = x[31:16]; e = x[15:0]; w = 1; end
      5'h0e: begin x = ub << ua; r = x[15:0]; e = x[31:16]; w = 1; end
      default: ;
    endcase
    return {w, e, r};
  endfunction

  function automatic int exp_lat(logic [4:0] op);
    case (op)
      5'h02, 5'h03, 5'h04, 5'h05, 5'h0c, 5'h0d, 5'h0e: return 2;
      5'h06, 5'h07, 5'h08: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic issue(input logic [4:0] op, input logic [15:0] b,
                       input logic [15:0] a, input string tag);
    exp_t e;
    logic [32:0] m;
    m = model(op, b, a);
    e.res = m[15:0]; e.ex = m[31:16]; e.we = m[32];
    e.lat = exp_lat(op); e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_b = b; in_a = a;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    q.push_back(e);
    in_valid = 1'b0;
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (prev_stall) begin
        chk(out_valid && out_res == prev_res && out_ex == prev_ex && out_ex_we == prev_we,
            "R2", "hold", {out_res, out_ex}, {prev_res, prev_ex});
      end
      if (out_valid) begin
        chk(!in_ready, "R1", "ready while result pending", in_ready, 0);
        if (q.size() == 0) chk(0, "R1", "unexpected result", out_res, 0);
        else begin
          if (!seen) begin
            seen = 1;
            chk(cyc - acc_cyc == q[0].lat - 1, "R3", "latency",
                cyc - acc_cyc + 1, q[0].lat);
          end
          if (out_ready) begin
            chk(out_res == q[0].res, q[0].tag, "result", out_res, q[0].res);
            chk(out_ex == q[0].ex, q[0].tag, "excess", out_ex, q[0].ex);
            chk(out_ex_we == q[0].we, q[0].tag, "excess write", out_ex_we, q[0].we);
            void'(q.pop_front());
            seen = 0;
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res = out_res; prev_ex = out_ex; prev_we = out_ex_we;
    end
  end

  task automatic run_set();
    issue(5'h01, 16'h1111, 16'hbeef, "R11");
    issue(5'h02, 16'h1234, 16'h0101, "R4");
    issue(5'h02, 16'hffff, 16'h0001, "R4");
    issue(5'h03, 16'h0005, 16'h0003, "R5");
    issue(5'h03, 16'h0003, 16'h0005, "R5");
    issue(5'h04, 16'h1234, 16'h0100, "R6");
    issue(5'h05, 16'hfffe, 16'h0003, "R6");
    issue(5'h06, 16'h0007, 16'h0002, "R7");
    issue(5'h07, 16'hfff9, 16'h0002, "R7");
    issue(5'h07, 16'h8000, 16'hffff, "R7");
    issue(5'h06, 16'h1234, 16'h0000, "R8");
    issue(5'h07, 16'h8001, 16'h0000, "R8");
    issue(5'h08, 16'h0007, 16'h0000, "R8");
    issue(5'h08, 16'h0017, 16'h0005, "R11");
    issue(5'h09, 16'hf0f0, 16'h3c3c, "R11");
    issue(5'h0a, 16'hf0f0, 16'h3c3c, "R11");
    issue(5'h0b, 16'hf0f0, 16'h3c3c, "R11");
    issue(5'h0c, 16'h8001, 16'h0001, "R9");
    issue(5'h0c, 16'habcd, 16'd20, "R9");
    issue(5'h0d, 16'h8000, 16'h0004, "R9");
    issue(5'h0d, 16'h8000, 16'h0100, "R9");
    issue(5'h0e, 16'h8001, 16'h0001, "R10");
    issue(5'h0e, 16'h00ff, 16'd16, "R10");
    issue(5'h00, 16'h5a5a, 16'h1234, "R12");
    issue(5'h1f, 16'h0bad, 16'h0001, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    run_set();
    stall_mode = 1;
    run_set();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1;
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule